// File: doc/BRIEF.md
# Single-Channel Byte Transfer Engine

This block moves bytes, one at a time, from a source address to a destination address on a simple request/ready bus. Each side can be memory or 16-bit I/O space, and each side can step its address up, step it down, or keep it fixed. Software loads a source address, a destination address, a byte count and a mode word through a small register port. It then sets the enable bit in a control word. For each byte the engine runs one bus read into a holding register and then one bus write of that byte.

Three request sources are available. The first is an external request pin, synchronised into the clock domain and sensed on its rising edge. The second is the same pin sensed on its level. The third is a pair of flags from an on-chip serial port, "transmit register empty" and "receive register full", which replace the pin. When the count runs out, the engine clears its own enable bit. It raises an interrupt if software has allowed one. The enable bit is guarded by a mask bit that must be written as 0 in the same access.

Top module: `dma_channel`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is 0 and `bus_req` is 0.
- R2: Each byte is moved by a read cycle (`bus_we`=0) and then, on the next cycle, a write cycle (`bus_we`=1) that carries the byte returned by the read. A cycle holds its address and direction until `bus_ready` is 1 at a clock edge, and the bus goes idle for at least one cycle after each write.
- R3: Mode bits [1:0] give the source step and bits [4:3] give the destination step: 0 adds one, 1 subtracts one, 2 or 3 holds the address. The step is applied after each completed byte.
- R4: Mode bit 2 marks the source as I/O and bit 5 marks the destination as I/O. An I/O cycle drives `bus_io`=1 and forces `bus_addr` bits above bit 15 to zero, while the address register keeps its full value.
- R5: The count register (address 2) drops by one per byte. When the last byte's write completes, the enable bit (control bit 0) clears by itself.
- R6: A count of 0 moves 65536 bytes. After one byte it reads 0xFFFF and the channel stays enabled.
- R7: A control write (address 4) changes the enable bit only when mask bit 1 of the same write is 0. Otherwise enable keeps its value and no transfer starts.
- R8: With mode bit 6 set (edge sensing) and bit 7 clear, exactly one byte is moved per rising edge of `dreq_in`.
- R9: With mode bits 6 and 7 clear (level sensing), bytes keep moving while `dreq_in` is high. Transfers stop within a few cycles of it going low.
- R10: With mode bit 7 set, `dreq_in` is ignored. The request is `ser_tx_empty` when the destination is I/O and `ser_rx_full` otherwise, sensed on level.
- R11: Control bit 2 enables the interrupt. If it is set, `irq` rises the cycle after the last byte's write completes. If it is clear, `irq` stays 0. Any control write clears `irq`, and control bit 3 reads its state.
- R12: Registers read back on `reg_rdata` combinationally: address 0 is source, 1 is destination, 2 is count, 3 is mode, and 4 is control with the current stepped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data |
| dreq_in | input | 1 | External transfer request |
| ser_tx_empty | input | 1 | Serial port transmit register empty |
| ser_rx_full | input | 1 | Serial port receive register full |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 for write cycle, 0 for read |
| bus_io | output | 1 | Cycle targets I/O space |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, taken when ready |
| bus_ready | input | 1 | Completes the current cycle |
| irq | output | 1 | Termination interrupt |

## Verification
A register write takes effect at the edge that samples it, and the readback is valid in the next cycle. A bus cycle completes at the edge where `bus_ready` is high. The write cycle follows at the next edge, and `irq` rises one edge after the final write completes. An edge request starts a read about three cycles after the pin rises, because of the two synchroniser stages and the edge and pending registers. The bench's reference model predicts each handshake's address, direction and data at the cycle it completes, and it predicts `irq` on every cycle. Where request latency is not fixed (edge and level requests), the checks let the transfers settle and then compare byte totals and register readback, so exact latency is never assumed.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_SRC  = 3'd0;
    localparam logic [REG_AW-1:0] REG_DST  = 3'd1;
    localparam logic [REG_AW-1:0] REG_CNT  = 3'd2;
    localparam logic [REG_AW-1:0] REG_MODE = 3'd3;
    localparam logic [REG_AW-1:0] REG_CTRL = 3'd4;

    localparam int CTL_EN      = 0;
    localparam int CTL_EN_MASK = 1;
    localparam int CTL_IE      = 2;
    localparam int CTL_IRQ     = 3;

    typedef enum logic [1:0] {
        STEP_UP   = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_KEEP = 2'd2
    } step_e;

    // bit 7 serial request, 6 edge sense, 5 dst io, 4:3 dst step, 2 src io, 1:0 src step
    typedef struct packed {
        logic       serial_req;
        logic       edge_sense;
        logic       dst_io;
        logic [1:0] dst_step;
        logic       src_io;
        logic [1:0] src_step;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    function automatic logic [31:0] advance(input logic [31:0] a, input logic [1:0] code);
        case (code)
            STEP_UP:   return a + 32'd1;
            STEP_DOWN: return a - 32'd1;
            default:   return a;
        endcase
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              byte_done,
    input  logic              last_byte,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output mode_t             mode_q,
    output logic              en_q,
    output logic              irq_q,
    output logic [ADDR_W-1:0] reg_rdata
);

    logic ie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (byte_done) begin
                src_q <= ADDR_W'(advance(32'(src_q), mode_q.src_step));
                dst_q <= ADDR_W'(advance(32'(dst_q), mode_q.dst_step));
                cnt_q <= cnt_q - 1'b1;
                if (last_byte) begin
                    en_q <= 1'b0;
                    if (ie_q) irq_q <= 1'b1;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    REG_SRC:  src_q  <= reg_wdata;
                    REG_DST:  dst_q  <= reg_wdata;
                    REG_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
                    REG_MODE: mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
                    REG_CTRL: begin
                        ie_q  <= reg_wdata[CTL_IE];
                        irq_q <= 1'b0;
                        if (!reg_wdata[CTL_EN_MASK]) en_q <= reg_wdata[CTL_EN];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_SRC:  reg_rdata = src_q;
            REG_DST:  reg_rdata = dst_q;
            REG_CNT:  reg_rdata[CNT_W-1:0]  = cnt_q;
            REG_MODE: reg_rdata[MODE_W-1:0] = mode_q;
            REG_CTRL: begin
                reg_rdata[CTL_EN]  = en_q;
                reg_rdata[CTL_IE]  = ie_q;
                reg_rdata[CTL_IRQ] = irq_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_req.sv
module dma_req #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dreq_in,
    input  logic ser_tx_empty,
    input  logic ser_rx_full,
    input  logic use_serial,
    input  logic edge_sense,
    input  logic dst_io,
    input  logic enable,
    input  logic take,
    output logic req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   level;
    logic                   rise;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], dreq_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= dreq_in;
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];
    assign rise  = level & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= level;
            if (!enable)   pend_q <= 1'b0;
            else if (rise) pend_q <= 1'b1;
            else if (take) pend_q <= 1'b0;
        end
    end

    always_comb begin
        if (use_serial)      req = dst_io ? ser_tx_empty : ser_rx_full;
        else if (edge_sense) req = pend_q;
        else                 req = level;
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int IO_AW  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              req,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              src_io,
    input  logic              dst_io,
    input  logic              bus_ready,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              take,
    output logic              byte_done,
    output logic              last_byte
);

    localparam logic [ADDR_W-1:0] IO_MASK = ADDR_W'((64'd1 << IO_AW) - 64'd1);

    state_e            st_q;
    logic [BYTE_W-1:0] hold_q;
    logic [ADDR_W-1:0] raw_addr;

    always_comb begin
        take      = (st_q == ST_IDLE) && enable && req;
        bus_req   = (st_q != ST_IDLE);
        bus_we    = (st_q == ST_WRITE);
        bus_io    = bus_we ? dst_io : src_io;
        raw_addr  = bus_we ? dst : src;
        bus_addr  = bus_io ? (raw_addr & IO_MASK) : raw_addr;
        bus_wdata = hold_q;
        byte_done = (st_q == ST_WRITE) && bus_ready;
        last_byte = byte_done && (cnt == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE:  if (take) st_q <= ST_READ;
                ST_READ:  if (bus_ready) begin
                    hold_q <= bus_rdata;
                    st_q   <= ST_WRITE;
                end
                ST_WRITE: if (bus_ready) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              dreq_in,
    input  logic              ser_tx_empty,
    input  logic              ser_rx_full,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    output logic              irq
);

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    mode_t             mode_q;
    logic              en_q, irq_q, req, take, byte_done, last_byte;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .byte_done(byte_done), .last_byte(last_byte),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .mode_q(mode_q),
        .en_q(en_q), .irq_q(irq_q), .reg_rdata(reg_rdata)
    );

    dma_req #(.SYNC_STAGES(SYNC_STAGES)) req_i (
        .clk(clk), .rst(rst), .dreq_in(dreq_in), .ser_tx_empty(ser_tx_empty),
        .ser_rx_full(ser_rx_full), .use_serial(mode_q.serial_req),
        .edge_sense(mode_q.edge_sense), .dst_io(mode_q.dst_io),
        .enable(en_q), .take(take), .req(req)
    );

    dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst(rst), .enable(en_q), .req(req), .src(src_q), .dst(dst_q),
        .cnt(cnt_q), .src_io(mode_q.src_io), .dst_io(mode_q.dst_io),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_io(bus_io), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .take(take), .byte_done(byte_done),
        .last_byte(last_byte)
    );

    assign irq = irq_q;

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_io,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_ready,
    input logic              irq
);

    assert_hold_while_waiting_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_io)));

    assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && !bus_we) |=> (bus_req && bus_we));

    assert_data_forwarded_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && !bus_we) |=> (bus_wdata == $past(bus_rdata)));

    assert_idle_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && bus_we) |=> !bus_req);

    assert_io_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_io) |-> ((bus_addr >> 16) == '0));

    assert_irq_rises_at_end_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(bus_req && bus_we && bus_ready));

    assert_irq_falls_on_write_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(reg_wr));

endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .bus_req(bus_req), .bus_we(bus_we),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
);

// File: tb/dma_channel_tb_top.sv
module dma_channel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          dreq_in = 1'b0, ser_tx_empty = 1'b0, ser_rx_full = 1'b0;
    logic          bus_req, bus_we, bus_io, irq;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          bus_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_channel dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq_in(dreq_in),
        .ser_tx_empty(ser_tx_empty), .ser_rx_full(ser_rx_full),
        .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a, input logic io);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ (io ? 8'hC3 : 8'h3C);
    endfunction

    assign bus_rdata = pat(bus_addr, bus_io);

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] code);
        if (code == 2'd0) return a + 1'b1;
        if (code == 2'd1) return a - 1'b1;
        return a;
    endfunction

    function automatic logic [AW-1:0] on_bus(input logic [AW-1:0] a, input logic io);
        return io ? (a & 20'h0FFFF) : a;
    endfunction

    function automatic logic [7:0] mk_mode(input logic [1:0] ss, input logic sio,
                                           input logic [1:0] ds, input logic dio,
                                           input logic edg, input logic ser);
        return {ser, edg, dio, ds, sio, ss};
    endfunction

    // reference model
    logic [AW-1:0] m_src = '0, m_dst = '0;
    logic [15:0]   m_cnt = '0;
    logic [7:0]    m_mode = '0;
    bit            m_en = 0, m_ie = 0, m_irq = 0;
    logic [7:0]    hold_q[$];
    int            n_moved = 0;
    int            n_checks = 0, n_fail = 0, cyc = 0;
    bit            ready_stall = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        bus_ready = ready_stall ? (cyc % 3 != 0) : 1'b1;
    end

    always @(negedge clk) begin
        #1;
        if (cyc > WATCHDOG) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            report();
        end
        if (!rst) begin
            check(irq === m_irq, "R11 irq level", irq, m_irq);
            if (bus_req && bus_ready) begin
                if (!bus_we) begin
                    check(m_en, "R7 read while disabled", 1, m_en);
                    check(hold_q.size() == 0, "R2 read before write", hold_q.size(), 0);
                    check(bus_addr == on_bus(m_src, m_mode[2]), "R3/R4 source addr",
                          bus_addr, on_bus(m_src, m_mode[2]));
                    check(bus_io == m_mode[2], "R4 source io", bus_io, m_mode[2]);
                    hold_q.push_back(pat(on_bus(m_src, m_mode[2]), m_mode[2]));
                end else begin
                    check(hold_q.size() == 1, "R2 write without read", hold_q.size(), 1);
                    check(bus_addr == on_bus(m_dst, m_mode[5]), "R3/R4 dest addr",
                          bus_addr, on_bus(m_dst, m_mode[5]));
                    check(bus_io == m_mode[5], "R4 dest io", bus_io, m_mode[5]);
                    if (hold_q.size() > 0) begin
                        logic [7:0] d;
                        d = hold_q.pop_front();
                        check(bus_wdata == d, "R2 write data", bus_wdata, d);
                    end
                    m_src = stepped(m_src, m_mode[1:0]);
                    m_dst = stepped(m_dst, m_mode[4:3]);
                    if (m_cnt == 16'd1) begin
                        m_en = 0;
                        if (m_ie) m_irq = 1;
                    end
                    m_cnt = m_cnt - 1'b1;
                    n_moved++;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_src = reg_wdata;
                    3'd1: m_dst = reg_wdata;
                    3'd2: m_cnt = reg_wdata[15:0];
                    3'd3: m_mode = reg_wdata[7:0];
                    3'd4: begin
                        m_ie = reg_wdata[2];
                        m_irq = 0;
                        if (!reg_wdata[1]) m_en = reg_wdata[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [AW-1:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int t = 0; t < 3000 && m_en; t++) @(negedge clk);
        idle(3);
    endtask

    task automatic pulse();
        @(negedge clk); dreq_in = 1'b1;
        idle(2);        dreq_in = 1'b0;
        idle(10);
    endtask

    initial begin
        int base, d1;
        idle(3);
        rst = 1'b0;
        // R1 reset state
        for (int r = 0; r < 5; r++) rd(3'(r), '0, "R1 register after reset");
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        check(bus_req == 1'b0, "R1 bus idle after reset", bus_req, 0);

        // R2 R3 R4 R5 R11: mem inc -> io fixed, level, stalls, interrupt on
        ready_stall = 1;
        wr(3'd0, 20'h12340);
        wr(3'd1, 20'hF5678);
        wr(3'd2, 20'd5);
        wr(3'd3, 20'(mk_mode(2'd0, 0, 2'd2, 1, 0, 0)));
        dreq_in = 1'b1;
        base = n_moved;
        wr(3'd4, 20'b0101);
        wait_done();
        dreq_in = 1'b0;
        check(n_moved - base == 5, "R5 bytes moved", n_moved - base, 5);
        rd(3'd2, 20'd0, "R5 count exhausted");
        rd(3'd0, 20'h12345, "R3 source incremented");
        rd(3'd1, 20'hF5678, "R4 io register keeps upper bits");
        rd(3'd4, 20'b1100, "R5 R11 enable cleared, irq flagged");
        check(irq == 1'b1, "R11 irq raised", irq, 1);
        wr(3'd4, 20'b0100);
        idle(2);
        check(irq == 1'b0, "R11 irq cleared by write", irq, 0);

        // R3 decrement both sides, R11 interrupt off
        ready_stall = 0;
        wr(3'd0, 20'h30010);
        wr(3'd1, 20'h00100);
        wr(3'd2, 20'd3);
        wr(3'd3, 20'(mk_mode(2'd1, 1, 2'd1, 0, 0, 0)));
        dreq_in = 1'b1;
        wr(3'd4, 20'b0001);
        wait_done();
        dreq_in = 1'b0;
        rd(3'd0, 20'h3000D, "R3 source decremented");
        rd(3'd1, 20'h000FD, "R3 dest decremented");
        rd(3'd4, 20'b0000, "R11 no irq when disabled");
        check(irq == 1'b0, "R11 irq stays low", irq, 0);

        // R7 enable mask
        wr(3'd0, 20'h00040);
        wr(3'd1, 20'h00080);
        wr(3'd2, 20'd4);
        wr(3'd3, 20'(mk_mode(2'd0, 0, 2'd0, 0, 0, 0)));
        dreq_in = 1'b1;
        base = n_moved;
        wr(3'd4, 20'b0011);
        idle(20);
        rd(3'd4, 20'b0000, "R7 masked enable ignored");
        check(n_moved == base, "R7 no transfer when masked", n_moved - base, 0);
        wr(3'd4, 20'b0001);
        wait_done();
        dreq_in = 1'b0;
        check(n_moved - base == 4, "R7 unmasked enable runs", n_moved - base, 4);

        // R8 edge sensing then R9 level stop
        wr(3'd0, 20'h00200);
        wr(3'd1, 20'h00800);
        wr(3'd2, 20'd10);
        wr(3'd3, 20'(mk_mode(2'd0, 0, 2'd0, 0, 1, 0)));
        idle(5);
        base = n_moved;
        wr(3'd4, 20'b0001);
        pulse(); pulse(); pulse();
        idle(20);
        check(n_moved - base == 3, "R8 one byte per edge", n_moved - base, 3);
        rd(3'd2, 20'd7, "R8 count after three edges");
        wr(3'd3, 20'(mk_mode(2'd0, 0, 2'd0, 0, 0, 0)));
        base = n_moved;
        dreq_in = 1'b1;
        idle(8);
        dreq_in = 1'b0;
        idle(30);
        d1 = n_moved - base;
        check(d1 > 0 && d1 < 7, "R9 level moved some bytes", d1, 1);
        idle(30);
        check(n_moved - base == d1, "R9 level stops when low", n_moved - base, d1);
        rd(3'd2, 20'(7 - d1), "R12 count readback");
        dreq_in = 1'b1;
        wait_done();
        dreq_in = 1'b0;
        rd(3'd0, 20'h0020A, "R12 source readback after ten");

        // R10 serial request, transmit side
        wr(3'd0, 20'h00400);
        wr(3'd1, 20'h00021);
        wr(3'd2, 20'd4);
        wr(3'd3, 20'(mk_mode(2'd0, 0, 2'd2, 1, 0, 1)));
        dreq_in = 1'b1; ser_tx_empty = 1'b0; ser_rx_full = 1'b1;
        base = n_moved;
        wr(3'd4, 20'b0001);
        idle(30);
        check(n_moved == base, "R10 pin and rx ignored", n_moved - base, 0);
        ser_tx_empty = 1'b1;
        wait_done();
        check(n_moved - base == 4, "R10 tx-empty drives writes", n_moved - base, 4);

        // R10 serial request, receive side
        wr(3'd0, 20'h00030);
        wr(3'd1, 20'h00500);
        wr(3'd2, 20'd2);
        wr(3'd3, 20'(mk_mode(2'd2, 1, 2'd0, 0, 0, 1)));
        ser_tx_empty = 1'b1; ser_rx_full = 1'b0;
        base = n_moved;
        wr(3'd4, 20'b0001);
        idle(30);
        check(n_moved == base, "R10 tx ignored for reads", n_moved - base, 0);
        ser_rx_full = 1'b1;
        wait_done();
        check(n_moved - base == 2, "R10 rx-full drives reads", n_moved - base, 2);
        ser_rx_full = 1'b0; ser_tx_empty = 1'b0; dreq_in = 1'b0;

        // R6 zero count means full range
        wr(3'd0, 20'h00600);
        wr(3'd1, 20'h00700);
        wr(3'd2, 20'd0);
        wr(3'd3, 20'(mk_mode(2'd0, 0, 2'd0, 0, 1, 0)));
        idle(5);
        base = n_moved;
        wr(3'd4, 20'b0001);
        pulse();
        idle(10);
        check(n_moved - base == 1, "R6 one byte moved", n_moved - base, 1);
        rd(3'd2, 20'h0FFFF, "R6 count wraps to 0xFFFF");
        rd(3'd4, 20'b0001, "R6 channel still enabled");
        wr(3'd4, 20'b0000);
        idle(5);
        rd(3'd4, 20'b0000, "R7 software disable");
        report();
    end

endmodule